// File: doc/BRIEF.md
# Refresh Slot Decoder and Access Gate

This block sits beside the display controller's slot sequencer. Each time the sequencer moves on to a new access slot of a scan line, it presents the slot number together with the current horizontal mode, the DMA state and whether the display is fetching. The block then decides two things. First, whether the slot is reserved for video-memory refresh. Second, whether the slot may be handed to an external access, meaning a CPU transfer or a DMA transfer.

Refresh slots sit at fixed, irregular positions that depend on the mode. In the wide mode, the end of the line is also reserved from a fixed slot onward. A colour-RAM DMA write additionally blocks a short window of slots at the start of each line. Both results are registered and stay valid for the whole slot. They change only when the slot-advance strobe is seen. Choosing among several external requesters is left to the logic downstream.

Top module: `rfs_gate`

## Requirements
- R1: After reset, `refresh_q` and `ext_grant_q` are both 0 and stay 0 until the first cycle with `slot_adv` high.
- R2: With `wide_mode`=1, slots 37, 69, 102, 133, 165 and 197 give `refresh_q`=1.
- R3: With `wide_mode`=1, every slot of 210 or above gives `refresh_q`=1.
- R4: With `wide_mode`=1, slots 0 to 5 give `refresh_q`=1 exactly when `dma_run`=1 and `dma_code` equals the colour-RAM write code (default 4'b0011). With any other code, or with no DMA running, those slots are not refresh slots.
- R5: With `wide_mode`=0, slots 24, 56, 88, 120 and 152 give `refresh_q`=1. No other slot of 5 or above is a refresh slot in this mode, including slots of 210 and above.
- R6: With `wide_mode`=0, slots 0 to 4 give `refresh_q`=1 exactly when `dma_run`=1 and `dma_code` equals the colour-RAM write code. Slot 5 is never blocked by this rule.
- R7: `ext_grant_q` is 1 exactly when the slot is not a refresh slot and `disp_active`=0.
- R8: The results for a slot appear on `refresh_q` and `ext_grant_q` in the cycle after `slot_adv` is sampled high. The outputs hold their values in every cycle that follows a cycle with `slot_adv` low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_adv | input | 1 | Strobe: a new slot starts, sample the inputs |
| slot_idx | input | SLOT_W (8) | Slot number within the line |
| wide_mode | input | 1 | 1 = wide horizontal mode, 0 = narrow |
| dma_run | input | 1 | A DMA transfer is in progress |
| dma_code | input | CODE_W (4) | Target/direction code of the running DMA |
| disp_active | input | 1 | Display is enabled and fetching on an active line |
| refresh_q | output | 1 | Current slot is reserved for refresh |
| ext_grant_q | output | 1 | Current slot may serve an external access |

## Verification
On every cycle, the assertions check the hold rule between strobes, the blocking of grants while the display fetches, the end-of-line tail in wide mode, and the absence of that tail in narrow mode. They also check that the line-start window stays open without a colour-RAM DMA, that the listed wide-mode positions are marked, and that the outputs are quiet after reset. Two things are shown only by the bench's scenarios, which compare every slot against an independent model. One is the exact set of irregular positions in each mode. The other is the precise edges of the line-start windows, slot 5 against slot 6 and 4 against 5, along with the code comparison that separates colour-RAM writes from other DMA codes.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Registered per-slot decision
    typedef struct packed {
        logic refresh;
        logic grant;
    } rfs_state_t;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } rfs_mode_e;

    localparam int WIDE_NPOS   = 6;
    localparam int NARROW_NPOS = 5;

    localparam int WIDE_POS   [WIDE_NPOS]   = '{37, 69, 102, 133, 165, 197};
    localparam int NARROW_POS [NARROW_NPOS] = '{24, 56, 88, 120, 152};

    localparam int WIDE_TAIL_START = 210;
    localparam int WIDE_LS_WIN     = 6;
    localparam int NARROW_LS_WIN   = 5;

endpackage

// File: rtl/rfs_pos_match.sv
// Flags a slot that equals any entry of a fixed position list.
module rfs_pos_match #(
    parameter int SLOT_W = 8,
    parameter int NPOS   = 1,
    parameter int POS [NPOS] = '{0}
) (
    input  logic [SLOT_W-1:0] slot_idx,
    output logic              hit
);
    logic [NPOS-1:0] eq;

    for (genvar i = 0; i < NPOS; i++) begin : g_cmp
        localparam logic [SLOT_W-1:0] POS_V = SLOT_W'(POS[i]);
        assign eq[i] = (slot_idx == POS_V);
    end

    assign hit = |eq;
endmodule

// File: rtl/rfs_linestart.sv
// Blocks the first WIN slots of a line while a colour-RAM DMA write runs.
module rfs_linestart #(
    parameter int          SLOT_W    = 8,
    parameter int          CODE_W    = 4,
    parameter int          WIN       = 6,
    parameter logic [CODE_W-1:0] CRAM_CODE = 4'b0011
) (
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              dma_run,
    input  logic [CODE_W-1:0] dma_code,
    output logic              blocked
);
    localparam logic [SLOT_W-1:0] WIN_V = SLOT_W'(WIN);

    logic in_win;
    logic cram_wr;

    assign in_win  = (slot_idx < WIN_V);
    assign cram_wr = dma_run && (dma_code == CRAM_CODE);
    assign blocked = in_win && cram_wr;
endmodule

// File: rtl/rfs_gate.sv
module rfs_gate
    import rfs_pkg::*;
#(
    parameter int               SLOT_W    = 8,
    parameter int               CODE_W    = 4,
    parameter logic [CODE_W-1:0] CRAM_CODE = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_adv,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              wide_mode,
    input  logic              dma_run,
    input  logic [CODE_W-1:0] dma_code,
    input  logic              disp_active,
    output logic              refresh_q,
    output logic              ext_grant_q
);
    localparam logic [SLOT_W-1:0] TAIL_V = SLOT_W'(WIDE_TAIL_START);

    logic wide_pos_hit, narrow_pos_hit;
    logic wide_ls_blk, narrow_ls_blk;
    logic wide_tail;
    logic wide_ref, narrow_ref, slot_ref;
    rfs_mode_e mode;

    rfs_pos_match #(.SLOT_W(SLOT_W), .NPOS(WIDE_NPOS), .POS(WIDE_POS)) u_wide_pos (
        .slot_idx (slot_idx),
        .hit      (wide_pos_hit)
    );

    rfs_pos_match #(.SLOT_W(SLOT_W), .NPOS(NARROW_NPOS), .POS(NARROW_POS)) u_narrow_pos (
        .slot_idx (slot_idx),
        .hit      (narrow_pos_hit)
    );

    rfs_linestart #(.SLOT_W(SLOT_W), .CODE_W(CODE_W), .WIN(WIDE_LS_WIN), .CRAM_CODE(CRAM_CODE)) u_wide_ls (
        .slot_idx (slot_idx),
        .dma_run  (dma_run),
        .dma_code (dma_code),
        .blocked  (wide_ls_blk)
    );

    rfs_linestart #(.SLOT_W(SLOT_W), .CODE_W(CODE_W), .WIN(NARROW_LS_WIN), .CRAM_CODE(CRAM_CODE)) u_narrow_ls (
        .slot_idx (slot_idx),
        .dma_run  (dma_run),
        .dma_code (dma_code),
        .blocked  (narrow_ls_blk)
    );

    assign mode       = rfs_mode_e'(wide_mode);
    assign wide_tail  = (slot_idx >= TAIL_V);
    assign wide_ref   = wide_pos_hit || wide_tail || wide_ls_blk;
    assign narrow_ref = narrow_pos_hit || narrow_ls_blk;
    assign slot_ref   = (mode == MODE_WIDE) ? wide_ref : narrow_ref;

    rfs_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (slot_adv) begin
            state_d.refresh = slot_ref;
            state_d.grant   = !slot_ref && !disp_active;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign refresh_q   = state_q.refresh;
    assign ext_grant_q = state_q.grant;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) && !$past(slot_adv) |-> !refresh_q && !ext_grant_q);

    // R2
    wide_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_adv && wide_mode && (slot_idx == 8'd37 || slot_idx == 8'd102 || slot_idx == 8'd197)
        |=> refresh_q);

    // R3
    wide_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_adv && wide_mode && slot_idx >= 8'd210 |=> refresh_q);

    // R4
    wide_ls_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_adv && wide_mode && slot_idx < 8'd6 && !dma_run |=> !refresh_q);

    // R5
    narrow_no_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_adv && !wide_mode && slot_idx >= 8'd210 |=> !refresh_q);

    // R7
    grant_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_adv && disp_active |=> !ext_grant_q);

    // R7
    grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_grant_q |-> !refresh_q);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_adv |=> $stable(refresh_q) && $stable(ext_grant_q));
endmodule

// File: tb/rfs_gate_tb.sv
module rfs_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_adv = 1'b0;
    logic [7:0] slot_idx = '0;
    logic       wide_mode = 1'b0;
    logic       dma_run = 1'b0;
    logic [3:0] dma_code = '0;
    logic       disp_active = 1'b0;
    logic       refresh_q, ext_grant_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rfs_gate u_dut (
        .clk(clk), .rst_n(rst_n), .slot_adv(slot_adv), .slot_idx(slot_idx),
        .wide_mode(wide_mode), .dma_run(dma_run), .dma_code(dma_code),
        .disp_active(disp_active), .refresh_q(refresh_q), .ext_grant_q(ext_grant_q)
    );

    function automatic bit exp_ref(int s, bit w, bit dr, logic [3:0] c);
        bit cram = dr && (c == 4'b0011);
        if (w) return (s == 37 || s == 69 || s == 102 || s == 133 || s == 165 ||
                       s == 197 || s >= 210 || (s < 6 && cram));
        return (s == 24 || s == 56 || s == 88 || s == 120 || s == 152 || (s < 5 && cram));
    endfunction

    task automatic check(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, expv);
        end
    endtask

    // one slot: strobe on a negedge, check at the following negedge
    task automatic slot(int s, bit w, bit dr, logic [3:0] c, bit da, string req);
        bit er;
        @(negedge clk);
        slot_adv = 1'b1; slot_idx = 8'(s); wide_mode = w;
        dma_run = dr; dma_code = c; disp_active = da;
        er = exp_ref(s, w, dr, c);
        @(negedge clk);
        slot_adv = 1'b0;
        check(req, refresh_q, er);
        check("R7", ext_grant_q, !er && !da);
    endtask

    initial begin
        bit r0, g0;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        // R1: quiet in reset and just after
        check("R1", refresh_q, 1'b0);
        check("R1", ext_grant_q, 1'b0);
        rst_n = 1'b1;
        slot_idx = 8'd37; wide_mode = 1'b1;
        @(negedge clk);
        check("R1", refresh_q, 1'b0);
        check("R1", ext_grant_q, 1'b0);

        // R2 wide fixed positions and neighbours
        foreach (rfs_pkg::WIDE_POS[i]) begin
            slot(rfs_pkg::WIDE_POS[i], 1, 0, 4'h0, 0, "R2");
            slot(rfs_pkg::WIDE_POS[i] + 1, 1, 0, 4'h0, 0, "R2");
        end
        // R3 tail edges
        slot(209, 1, 0, 4'h0, 0, "R3");
        slot(210, 1, 0, 4'h0, 0, "R3");
        slot(255, 1, 0, 4'h0, 1, "R3");
        // R4 line-start window in wide mode
        slot(0, 1, 1, 4'b0011, 0, "R4");
        slot(5, 1, 1, 4'b0011, 0, "R4");
        slot(6, 1, 1, 4'b0011, 0, "R4");
        slot(5, 1, 1, 4'b0001, 0, "R4");
        slot(3, 1, 0, 4'b0011, 0, "R4");
        // R5 narrow positions, no tail
        foreach (rfs_pkg::NARROW_POS[i]) slot(rfs_pkg::NARROW_POS[i], 0, 0, 4'h0, 0, "R5");
        slot(37, 0, 0, 4'h0, 0, "R5");
        slot(210, 0, 0, 4'h0, 0, "R5");
        // R6 narrow window edges
        slot(4, 0, 1, 4'b0011, 0, "R6");
        slot(5, 0, 1, 4'b0011, 0, "R6");
        slot(2, 0, 1, 4'b0111, 0, "R6");
        // R7 display active blocks grant
        slot(100, 1, 0, 4'h0, 1, "R7");
        slot(100, 1, 0, 4'h0, 0, "R7");

        // random mix with hold checks (R8)
        for (int n = 0; n < 1500; n++) begin
            slot($urandom_range(0, 255), 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 3) == 0) ? 4'b0011 : 4'($urandom), 1'($urandom), "R2-R6 random");
            r0 = refresh_q; g0 = ext_grant_q;
            repeat ($urandom_range(0, 2)) begin
                slot_idx = 8'($urandom); wide_mode = 1'($urandom);
                dma_run = 1'($urandom); dma_code = 4'($urandom); disp_active = 1'($urandom);
                @(negedge clk);
                check("R8", refresh_q, r0);
                check("R8", ext_grant_q, g0);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule